// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host side of a three-wire link to an octal 8-bit DAC register bank. A client hands it one write at a time, a 3-bit channel number and an 8-bit code, over a valid/ready handshake. The block turns each write into a 16-bit serial frame on an active-low select, a serial clock and a data line. The frame starts with five zero padding bits, which the receiver discards because it keeps only the last eleven bits it clocked in. The channel number follows, then the code, each most significant bit first.

The serial clock idles high. Select falls while the clock is high. The data line is updated only on falling clock edges, so the receiver samples a settled bit on every rising edge. After the last rising edge, select is held low for a set time and then released with the clock still high. Each clock phase, the hold after the last edge and the select-high gap between frames are counted in system clocks and set by parameters. The user picks these counts so that each interval meets the receiver's minimum times at the system clock rate in use.

Back-pressure: `in_ready` is high only while the block is idle. A request is taken on a rising system clock edge where `in_valid` and `in_ready` are both high. The client must hold `in_addr` and `in_data` steady while `in_valid` waits for `in_ready`. The taken request is copied into an internal register, so the input pins are free from the next cycle. `frame_done` marks the end of each frame.

Top module: `dac_link_writer`

## Requirements
- R1: A request is accepted on a clock edge where in_valid and in_ready are both high. in_ready is low from the cycle after acceptance until GAP_CYC cycles after select returns high, then it is high again.
- R2: Each frame has exactly 16 rising serial clock edges. The bits sampled on them, in order, are five 0 bits, in_addr[2] down to in_addr[0], then in_data[7] down to in_data[0].
- R3: While dac_cs_n is high, dac_sclk is high. dac_cs_n falls only while dac_sclk is high.
- R4: dac_sdo changes only in the cycle where dac_sclk falls or where dac_cs_n changes, so it is stable across every rising serial clock edge.
- R5: The first dac_sclk fall comes HALF_DIV cycles after dac_cs_n falls. Every later dac_sclk low or high phase inside a frame lasts exactly HALF_DIV cycles.
- R6: After the final rising serial clock edge, dac_cs_n stays low for HALF_DIV+HOLD_CYC cycles. It then rises with dac_sclk high.
- R7: Between frames dac_cs_n stays high for at least GAP_CYC+1 cycles. With in_valid held high, the gap is exactly GAP_CYC+1 cycles.
- R8: frame_done is high for exactly one cycle per frame: the cycle in which dac_cs_n has just risen, and no other.
- R9: After reset: dac_cs_n=1, dac_sclk=1, dac_sdo=0, frame_done=0, in_ready=1.
- R10: While a frame is in flight, in_valid, in_addr and in_data have no effect. The frame carries the accepted request, and no extra frame starts if in_valid drops before in_ready returns.
- R11: dac_sdo is 0 whenever dac_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_addr | input | ADDR_W (3) | Target channel number |
| in_data | input | DATA_W (8) | Code for the target channel |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdo | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-cycle pulse when select is released |

## Verification
The bench builds the block with HALF_DIV=5, HOLD_CYC=2 and GAP_CYC=4. These three counts are all different from one another, so a window that picks up the wrong count shows up in the measured lengths: a 167-cycle select-low time, a 7-cycle release hold, a 171-cycle busy time and a 5-cycle gap between back-to-back frames. The channel and code patterns include all zeros, all ones and alternating bits. These expose a misplaced padding bit, a swapped field or an off-by-one shift. Two further cases hold in_valid high into a second request and change the inputs mid-frame, which tests the holding register and the gap.

// File: rtl/dac_link_pkg.sv
package dac_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } link_state_e;

endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame
);
  localparam int PAD_W = FRAME_W - ADDR_W - DATA_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame = {{PAD_W{1'b0}}, addr, data};
    end else begin : g_nopad
      assign frame = {addr, data};
    end
  endgenerate
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  input  logic               flush,
  output logic               msb,
  output logic               last_bit
);
  localparam int BC_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic [FRAME_W-1:0] sr_q;
  logic [BC_W-1:0]    bcnt_q;

  assign msb      = sr_q[FRAME_W-1];
  assign last_bit = (bcnt_q == BC_W'(FRAME_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (load) begin
      sr_q   <= frame;
      bcnt_q <= '0;
    end else if (flush) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (shift) begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      bcnt_q <= bcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dac_link_ctrl.sv
module dac_link_ctrl
  import dac_link_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             expire,
  input  logic             last_bit,
  output logic             idle,
  output logic             load,
  output logic             shift,
  output logic             flush,
  output logic             tmr_clear,
  output logic [CNT_W-1:0] tmr_limit,
  output logic             cs_n,
  output logic             sclk,
  output logic             done
);
  link_state_e st_q, st_nxt;
  logic cs_n_q, sclk_q, done_q;

  assign idle      = (st_q == ST_IDLE);
  assign tmr_clear = idle || expire;
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign done      = done_q;

  always_comb begin
    unique case (st_q)
      ST_HOLD: tmr_limit = CNT_W'(HOLD_CYC);
      ST_GAP:  tmr_limit = CNT_W'(GAP_CYC);
      default: tmr_limit = CNT_W'(HALF_DIV);
    endcase
  end

  always_comb begin
    st_nxt = st_q;
    load   = 1'b0;
    shift  = 1'b0;
    flush  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (accept) begin st_nxt = ST_SETUP; load = 1'b1; end
      ST_SETUP: if (expire) st_nxt = ST_LOW;
      ST_LOW:   if (expire) st_nxt = ST_HIGH;
      ST_HIGH:  if (expire) begin
                  if (last_bit) st_nxt = ST_HOLD;
                  else begin st_nxt = ST_LOW; shift = 1'b1; end
                end
      ST_HOLD:  if (expire) begin st_nxt = ST_GAP; flush = 1'b1; end
      ST_GAP:   if (expire) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      cs_n_q <= !(st_nxt inside {ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD});
      sclk_q <= (st_nxt != ST_LOW);
      done_q <= (st_q == ST_HOLD) && expire;
    end
  end
endmodule

// File: rtl/dac_link_writer.sv
module dac_link_writer #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 4,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              frame_done
);
  localparam int MAX_A   = (HALF_DIV > HOLD_CYC) ? HALF_DIV : HOLD_CYC;
  localparam int MAX_LIM = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [FRAME_W-1:0] frame;
  logic               accept, expire, last_bit, idle;
  logic               load, shift, flush, tmr_clear;
  logic [CNT_W-1:0]   tmr_limit;

  assign in_ready = idle;
  assign accept   = in_valid && idle;

  dac_frame_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_pack (
    .addr (in_addr),
    .data (in_data),
    .frame(frame)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .expire(expire)
  );

  dac_bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .frame   (frame),
    .shift   (shift),
    .flush   (flush),
    .msb     (dac_sdo),
    .last_bit(last_bit)
  );

  dac_link_ctrl #(
    .HALF_DIV(HALF_DIV), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .expire   (expire),
    .last_bit (last_bit),
    .idle     (idle),
    .load     (load),
    .shift    (shift),
    .flush    (flush),
    .tmr_clear(tmr_clear),
    .tmr_limit(tmr_limit),
    .cs_n     (dac_cs_n),
    .sclk     (dac_sclk),
    .done     (frame_done)
  );
endmodule

// File: rtl/dac_link_writer_chk.sv
module dac_link_writer_chk #(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 4,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_sdo,
  input logic frame_done
);
  localparam logic [15:0] PH_LEN   = 16'(HALF_DIV);
  localparam logic [15:0] REL_LEN  = 16'(HALF_DIV + HOLD_CYC);
  localparam logic [15:0] GAP_LEN  = 16'(GAP_CYC);
  localparam logic [15:0] RISE_TOT = 16'(FRAME_W);

  logic        p_sclk, p_cs;
  logic [15:0] ph_cnt, rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sclk   <= 1'b1;
      p_cs     <= 1'b1;
      ph_cnt   <= 16'hFFFF;
      rise_cnt <= '0;
    end else begin
      p_sclk <= dac_sclk;
      p_cs   <= dac_cs_n;
      if ((dac_sclk != p_sclk) || (dac_cs_n != p_cs)) ph_cnt <= 16'd1;
      else if (ph_cnt != 16'hFFFF)                    ph_cnt <= ph_cnt + 16'd1;
      if (!dac_cs_n && p_cs)                          rise_cnt <= '0;
      else if (dac_sclk && !p_sclk && !dac_cs_n)      rise_cnt <= rise_cnt + 16'd1;
    end
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> rise_cnt == RISE_TOT);

  // R3
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> dac_sclk);

  // R3
  select_fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> dac_sclk);

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_sdo) |-> ($fell(dac_sclk) || !$stable(dac_cs_n)));

  // R5
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_sclk) |-> ph_cnt == PH_LEN);

  // R6
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (ph_cnt == REL_LEN) && dac_sclk);

  // R7
  select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> ph_cnt > GAP_LEN);

  // R8
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> frame_done);

  // R8
  done_only_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $rose(dac_cs_n));

  // R11
  idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sdo);
endmodule

bind dac_link_writer dac_link_writer_chk #(
  .FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .dac_cs_n  (dac_cs_n),
  .dac_sclk  (dac_sclk),
  .dac_sdo   (dac_sdo),
  .frame_done(frame_done)
);

// File: tb/dac_link_writer_tb.sv
module dac_link_writer_tb;
  localparam int H  = 5;
  localparam int HC = 2;
  localparam int GC = 4;
  localparam int LOW_LEN  = 33*H + HC;
  localparam int BUSY_LEN = 33*H + HC + GC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic in_ready, dac_cs_n, dac_sclk, dac_sdo, frame_done;

  int total = 0, fails = 0, cyc = 0;
  int last_evt = -1000, fall_cyc = 0, gap_len = 0, hold_len = 0, low_len = 0;
  int rises = 0, phase_bad = 0, sdo_bad = 0, done_bad = 0, idle_bad = 0, dones = 0;
  logic [15:0] cap = '0, last_frame = '0;
  logic p_sclk = 1'b1, p_cs = 1'b1, p_sdo = 1'b0;

  always #2 clk = ~clk;

  dac_link_writer #(.HALF_DIV(H), .HOLD_CYC(HC), .GAP_CYC(GC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .frame_done(frame_done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // line monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_sclk != p_sclk) begin
        if (!dac_cs_n && (cyc - last_evt) != H) phase_bad++;
        if (dac_sclk) begin rises++; cap = {cap[14:0], dac_sdo}; end
        last_evt = cyc;
      end
      if (dac_cs_n != p_cs) begin
        if (!dac_cs_n) begin gap_len = cyc - last_evt; rises = 0; fall_cyc = cyc; end
        else begin hold_len = cyc - last_evt; low_len = cyc - fall_cyc; last_frame = cap; end
        last_evt = cyc;
      end
      if (dac_sdo != p_sdo && !(p_sclk && !dac_sclk) && dac_cs_n == p_cs) sdo_bad++;
      if (frame_done != (dac_cs_n && !p_cs)) done_bad++;
      if (frame_done) dones++;
      if (dac_cs_n && (!dac_sclk || dac_sdo)) idle_bad++;
    end
    p_sclk = dac_sclk;
    p_cs   = dac_cs_n;
    p_sdo  = dac_sdo;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, output int busy);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    busy = 0;
    while (!in_ready) begin busy++; @(negedge clk); end
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(dac_cs_n === 1'b1,   "R9 cs_n", int'(dac_cs_n), 1);
    chk(dac_sclk === 1'b1,   "R9 sclk", int'(dac_sclk), 1);
    chk(dac_sdo === 1'b0,    "R9 sdo", int'(dac_sdo), 0);
    chk(frame_done === 1'b0, "R9 done", int'(frame_done), 0);
    chk(in_ready === 1'b1,   "R9 ready", int'(in_ready), 1);
  endtask

  task automatic t_frame(input logic [2:0] a, input logic [7:0] d);
    int busy;
    int d0 = dones;
    send(a, d, busy);
    chk(last_frame == {5'b0, a, d}, "R2 frame bits", int'(last_frame), int'({5'b0, a, d}));
    chk(rises == 16, "R2 rising edges", rises, 16);
    chk(low_len == LOW_LEN, "R5 select low length", low_len, LOW_LEN);
    chk(hold_len == H + HC, "R6 release hold", hold_len, H + HC);
    chk(busy == BUSY_LEN, "R1 ready low cycles", busy, BUSY_LEN);
    chk(dones == d0 + 1, "R8 done count", dones - d0, 1);
  endtask

  task automatic t_back_to_back();
    int d0 = dones;
    logic [15:0] first;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 3'd6; in_data = 8'h5A;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_addr = 3'd1; in_data = 8'hC3;
    while (dones == d0) @(negedge clk);
    #1 first = last_frame;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (dones == d0 + 1) @(negedge clk);
    #1;
    chk(first == {5'b0, 3'd6, 8'h5A}, "R2 first frame", int'(first), int'({5'b0, 3'd6, 8'h5A}));
    chk(last_frame == {5'b0, 3'd1, 8'hC3}, "R2 second frame", int'(last_frame), int'({5'b0, 3'd1, 8'hC3}));
    chk(gap_len == GC + 1, "R7 select gap", gap_len, GC + 1);
  endtask

  task automatic t_busy_ignore();
    int d0 = dones;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 3'd3; in_data = 8'h96;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_addr = 3'd4; in_data = 8'h69;
    repeat (40) @(negedge clk);
    in_valid = 1'b1; in_addr = 3'd7; in_data = 8'h00;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (GC + 20) @(negedge clk);
    #1;
    chk(last_frame == {5'b0, 3'd3, 8'h96}, "R10 frame unchanged", int'(last_frame), int'({5'b0, 3'd3, 8'h96}));
    chk(dones == d0 + 1, "R10 no extra frame", dones - d0, 1);
    chk(dac_cs_n === 1'b1, "R10 select stays high", int'(dac_cs_n), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(3'd0, 8'h00);
    t_frame(3'd7, 8'hFF);
    t_frame(3'd5, 8'hA5);
    t_frame(3'd2, 8'h3C);
    t_back_to_back();
    t_busy_ignore();
    chk(phase_bad == 0, "R5 phase lengths", phase_bad, 0);
    chk(sdo_bad == 0, "R4 data changes", sdo_bad, 0);
    chk(done_bad == 0, "R8 done alignment", done_bad, 0);
    chk(idle_bad == 0, "R3 R11 idle levels", idle_bad, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule